// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog with Configuration Lock

This block watches for a stalled processor. A down counter runs from a programmable reload value once the watchdog is switched on. The first time the count reaches zero the block raises an interrupt and starts the count again. If software has not cleared that interrupt when the count reaches zero a second time, the block escalates to a system reset request, but only when reset escalation is enabled. A pending interrupt can be steered to a non-maskable output instead of the ordinary interrupt line.

Software reaches the block over a simple single-cycle register bus: a write strobe, a 3-bit word address, write data, and read data that follows the address combinationally. Writing any value other than the unlock key into the lock register freezes the reload value and the control bits. Writing the key opens them again.

The behaviour is a four-state machine. IDLE is the state out of reset, where the counter holds. ARMED means the counter runs and nothing is pending. PENDING means the first time-out has happened and the interrupt is raised. RESET_REQ is terminal until `rst_n`. The named transitions are: arm (IDLE to ARMED, the cycle after the enable bit reads 1); first_expiry (ARMED to PENDING on a time-out); serviced (PENDING to ARMED on an interrupt-clear write); re_expiry (PENDING to PENDING on a time-out with escalation disabled, which reloads the count); escalate (PENDING to RESET_REQ on a time-out with escalation enabled).

Top module: `wdt_escalate`

## Requirements
- R1: After reset, the reload register (address 0) and the count (address 1) read 0xFFFFFFFF, control (address 2), lock (address 4) and status (address 5) read 0, and `irq_o`, `nmi_o` and `rst_req_o` are low.
- R2: When control bit 0 (enable) is set, the watchdog arms on the following cycle. From then on the count drops by one per cycle. A time-out is a cycle in which the count is 0 and the counter is neither written nor reloaded by a clear. On the first time-out the count reloads from address 0 and the interrupt goes pending (status bit 0).
- R3: A time-out while the interrupt is still pending, with control bit 1 (reset enable) set, raises `rst_req_o` (status bit 1). `rst_req_o` stays high, and the interrupt stays pending, until `rst_n` is asserted.
- R4: A time-out while the interrupt is pending, with reset enable clear, reloads the count, keeps the interrupt pending and leaves `rst_req_o` low.
- R5: Any write to address 3 clears a pending interrupt (outside RESET_REQ) and reloads the count from address 0.
- R6: An accepted write to address 0 stores the value and loads it into the count at the same clock edge.
- R7: Writing 0x1ACCE551 to address 4 unlocks the block, and writing any other value locks it. Address 4 reads 1 while locked and 0 while unlocked.
- R8: While the block is locked, writes to address 0 and address 2 have no effect.
- R9: Once control bit 0 has been set, writing 0 to it leaves it at 1. Only reset clears it.
- R10: Control bit 2 steers a pending interrupt to `nmi_o`. When that bit is clear the interrupt goes to `irq_o`. The two outputs are never high together.
- R11: A reload write or a clear in the same cycle that the count is 0 takes priority, so no time-out occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | System reset request |

## Verification
A corrupted state register or count shows up at the ports within one count period, because the interrupt lines or the reset request rise or fall on the wrong cycle. A register value that leaks past the lock shows up on the next read of that address. It also moves the next time-out, so a wrong reload value shows up a full period later. The reference model is compared on the three request outputs every cycle, which places any such error to the exact cycle. Register reads are compared against the model's copy of the register values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE,
        WD_ARMED,
        WD_PENDING,
        WD_RESET
    } wd_state_t;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_RELOAD = 3'd0;
    localparam logic [REG_AW-1:0] A_COUNT  = 3'd1;
    localparam logic [REG_AW-1:0] A_CTRL   = 3'd2;
    localparam logic [REG_AW-1:0] A_CLEAR  = 3'd3;
    localparam logic [REG_AW-1:0] A_LOCK   = 3'd4;
    localparam logic [REG_AW-1:0] A_STATUS = 3'd5;

    localparam int B_EN  = 0;
    localparam int B_RES = 1;
    localparam int B_NMI = 2;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int          W   = 32,
    parameter logic [W-1:0] KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      load_q,
    output logic              inten_q,
    output logic              resen_q,
    output logic              nmisel_q,
    output logic              locked_q,
    output logic              load_wr_ok,
    output logic              iclr_wr
);
    logic ctrl_wr_ok;
    logic lock_wr;

    always_comb begin
        load_wr_ok = wr_en && (addr == A_RELOAD) && !locked_q;
        ctrl_wr_ok = wr_en && (addr == A_CTRL) && !locked_q;
        iclr_wr    = wr_en && (addr == A_CLEAR);
        lock_wr    = wr_en && (addr == A_LOCK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q   <= '1;
            inten_q  <= 1'b0;
            resen_q  <= 1'b0;
            nmisel_q <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            if (load_wr_ok) load_q <= wdata;
            if (ctrl_wr_ok) begin
                inten_q  <= inten_q | wdata[B_EN];
                resen_q  <= wdata[B_RES];
                nmisel_q <= wdata[B_NMI];
            end
            if (lock_wr) locked_q <= (wdata != KEY);
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_now,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt_q,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '1;
        else if (load_now) cnt_q <= load_val;
        else if (dec)      cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      inten,
    input  logic      resen,
    input  logic      zero,
    input  logic      iclr,
    input  logic      load_wr,
    output wd_state_t state,
    output logic      run,
    output logic      timeout,
    output logic      pending,
    output logic      rst_req
);
    wd_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        run     = (state == WD_ARMED) || (state == WD_PENDING);
        timeout = run && zero && !load_wr && !iclr;
        nxt     = state;
        unique case (state)
            WD_IDLE:    if (inten) nxt = WD_ARMED;
            WD_ARMED:   if (timeout) nxt = WD_PENDING;
            WD_PENDING: begin
                if (iclr)                  nxt = WD_ARMED;
                else if (timeout && resen) nxt = WD_RESET;
            end
            WD_RESET:   nxt = WD_RESET;
            default:    nxt = WD_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == WD_PENDING) || (state == WD_RESET);
        rst_req = (state == WD_RESET);
    end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
    import wdt_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              rst_req_o
);
    logic [W-1:0] load_q;
    logic [W-1:0] cnt_q;
    logic inten_q, resen_q, nmisel_q, locked_q;
    logic load_wr_ok, iclr_wr;
    logic zero, run, timeout, pending, rst_req;
    logic load_now;
    logic [W-1:0] load_val;
    wd_state_t state;

    wdt_regs #(.W(W), .KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .load_q(load_q), .inten_q(inten_q), .resen_q(resen_q),
        .nmisel_q(nmisel_q), .locked_q(locked_q),
        .load_wr_ok(load_wr_ok), .iclr_wr(iclr_wr)
    );

    assign load_now = load_wr_ok || iclr_wr || timeout;
    assign load_val = load_wr_ok ? wdata : load_q;

    wdt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_now(load_now), .load_val(load_val),
        .dec(run && !zero), .cnt_q(cnt_q), .zero(zero)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .inten(inten_q), .resen(resen_q),
        .zero(zero), .iclr(iclr_wr), .load_wr(load_wr_ok),
        .state(state), .run(run), .timeout(timeout),
        .pending(pending), .rst_req(rst_req)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_RELOAD: rdata = load_q;
            A_COUNT:  rdata = cnt_q;
            A_CTRL:   begin
                rdata[B_EN]  = inten_q;
                rdata[B_RES] = resen_q;
                rdata[B_NMI] = nmisel_q;
            end
            A_LOCK:   rdata[0] = locked_q;
            A_STATUS: begin
                rdata[0] = pending;
                rdata[1] = rst_req;
            end
            default:  rdata = '0;
        endcase
    end

    assign irq_o     = pending && !nmisel_q;
    assign nmi_o     = pending && nmisel_q;
    assign rst_req_o = rst_req;
endmodule

// File: rtl/wdt_escalate_chk.sv
module wdt_escalate_chk
    import wdt_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] KEY = 32'h1ACCE551
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic              irq_o,
    input logic              nmi_o,
    input logic              rst_req_o,
    input logic [W-1:0]      load_q,
    input logic              locked_q,
    input logic              inten_q
);
    // R3
    escalate_after_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(irq_o || nmi_o));

    // R3
    reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);

    // R10
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && nmi_o));

    // R8
    locked_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RELOAD && locked_q) |=> $stable(load_q));

    // R9
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inten_q |=> inten_q);

    // R7
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LOCK && wdata == KEY) |=> !locked_q);
endmodule

bind wdt_escalate wdt_escalate_chk #(.W(W), .KEY(KEY)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o),
    .load_q(load_q), .locked_q(locked_q), .inten_q(inten_q)
);

// File: tb/wdt_escalate_test.sv
`timescale 1ns/1ps
module wdt_escalate_test;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic irq_o, nmi_o, rst_req_o;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_escalate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    // behavioural reference
    logic [31:0] m_cnt, m_load;
    bit m_en, m_res, m_nmi, m_locked, m_run, m_pend, m_rst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 32'hFFFF_FFFF; m_load = 32'hFFFF_FFFF;
            m_en = 0; m_res = 0; m_nmi = 0; m_locked = 0;
            m_run = 0; m_pend = 0; m_rst = 0;
        end else begin
            bit lw, cw, clr, kw, going, to;
            lw    = wr_en && addr == 3'd0 && !m_locked;
            cw    = wr_en && addr == 3'd2 && !m_locked;
            clr   = wr_en && addr == 3'd3;
            kw    = wr_en && addr == 3'd4;
            going = m_run && !m_rst;
            to    = going && m_cnt == 0 && !lw && !clr;
            if (lw)              m_cnt = wdata;
            else if (clr || to)  m_cnt = m_load;
            else if (going && m_cnt != 0) m_cnt = m_cnt - 1;
            if (clr && m_pend && !m_rst) m_pend = 0;
            else if (to) begin
                if (!m_pend)    m_pend = 1;
                else if (m_res) m_rst = 1;
            end
            m_run = m_run || m_en;
            if (lw) m_load = wdata;
            if (cw) begin
                m_en  = m_en || wdata[0];
                m_res = wdata[1];
                m_nmi = wdata[2];
            end
            if (kw) m_locked = (wdata != KEY);
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {29'd0, m_nmi, m_res, m_en};
            3'd4: return {31'd0, m_locked};
            3'd5: return {30'd0, m_rst, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the request outputs
    always @(negedge clk) begin
        if (rst_n && !done)
            chk({phase, " outputs"}, {29'd0, irq_o, nmi_o, rst_req_o},
                {29'd0, m_pend && !m_nmi, m_pend && m_nmi, m_rst});
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        addr = a;
        #1;
        chk(tag, rdata, model_read(a));
    endtask

    task automatic rd_exp(input string tag, input logic [2:0] a, input logic [31:0] e);
        addr = a;
        #1;
        chk(tag, rdata, e);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        done = 1'b1;
        checks++; fails++;
        $display("FAIL watchdog: run did not finish (all requirements), actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_exp("R1 reload", 3'd0, 32'hFFFF_FFFF);
        rd_exp("R1 count", 3'd1, 32'hFFFF_FFFF);
        rd_exp("R1 ctrl", 3'd2, 32'd0);
        rd_exp("R1 lock", 3'd4, 32'd0);
        rd_exp("R1 status", 3'd5, 32'd0);

        phase = "R6";
        wr(3'd0, 32'd20);
        rd_exp("R6 count after reload write", 3'd1, 32'd20);
        rd_exp("R6 reload", 3'd0, 32'd20);

        phase = "R2";
        wr(3'd2, 32'd1);
        repeat (30) @(negedge clk);
        rd_exp("R2 interrupt pending", 3'd5, 32'd1);
        chk("R2 irq line", {31'd0, irq_o}, 32'd1);
        rd("R2 count", 3'd1);

        phase = "R4";
        repeat (25) @(negedge clk);
        rd_exp("R4 pending kept, no reset", 3'd5, 32'd1);
        rd("R4 count", 3'd1);

        phase = "R5";
        wr(3'd3, 32'd0);
        rd_exp("R5 cleared", 3'd5, 32'd0);
        rd("R5 count reloaded", 3'd1);

        phase = "R9";
        wr(3'd2, 32'd0);
        rd_exp("R9 enable sticky", 3'd2, 32'd1);

        phase = "R7";
        wr(3'd4, 32'h1234_5678);
        rd_exp("R7 locked reads 1", 3'd4, 32'd1);
        phase = "R8";
        wr(3'd0, 32'd5);
        wr(3'd2, 32'd7);
        rd_exp("R8 reload unchanged", 3'd0, 32'd20);
        rd_exp("R8 ctrl unchanged", 3'd2, 32'd1);
        rd("R8 count", 3'd1);
        phase = "R7";
        wr(3'd4, KEY);
        rd_exp("R7 unlocked reads 0", 3'd4, 32'd0);

        phase = "R10";
        wr(3'd0, 32'd6);
        wr(3'd2, 32'd5);
        repeat (12) @(negedge clk);
        chk("R10 nmi high", {31'd0, nmi_o}, 32'd1);
        chk("R10 irq low", {31'd0, irq_o}, 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd1);

        phase = "R11";
        wr(3'd0, 32'd4);
        do @(negedge clk); while (m_cnt != 32'd1);
        wr(3'd0, 32'd9);
        rd_exp("R11 no time-out on reload write", 3'd5, 32'd0);
        rd("R11 count", 3'd1);
        do @(negedge clk); while (m_cnt != 32'd1);
        wr(3'd3, 32'd0);
        rd_exp("R11 no time-out on clear", 3'd5, 32'd0);

        phase = "R3";
        wr(3'd0, 32'd3);
        wr(3'd2, 32'd3);
        repeat (14) @(negedge clk);
        rd_exp("R3 reset requested", 3'd5, 32'd3);
        chk("R3 rst_req line", {31'd0, rst_req_o}, 32'd1);
        wr(3'd3, 32'd0);
        repeat (10) @(negedge clk);
        rd_exp("R3 reset sticky", 3'd5, 32'd3);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 released by reset", {31'd0, rst_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_exp("R1 reset state again", 3'd5, 32'd0);

        done = 1'b1;
        summary();
    end
endmodule